// File: doc/BRIEF.md
# I2C Target with Persistent Register Pointer

This block is an I2C target that gives a two-wire bus master access to a small internal array of byte registers. All accesses go through one register pointer. The first byte of a write transfer loads the pointer. Each later byte of that transfer is stored at the pointer, and the pointer then advances by one. A read transfer returns bytes starting at the pointer and advances it after every byte sent. The pointer keeps its value across STOP and START. A master can therefore send a write that carries only the pointer byte, then read from that location later, either after a repeated START or in a separate transfer.

The bus lines are sampled by a faster system clock through synchronizers. The clock line is never driven. The data line is driven open-drain: the output `sda_oe` pulls the pad low when it is 1 and releases it otherwise. A 2-bit strap input selects one of four 7-bit addresses. The block has no streaming interface. Data enters and leaves only over the bus, and the strap and the open-drain enable are plain level signals with no handshake.

Top module: `i2c_regptr_target`

## Requirements
- R1: START is detected as SDA falling while SCL is high, and STOP as SDA rising while SCL is high. After STOP the block releases SDA and ignores clock pulses until the next START.
- R2: The own address is 0x5A plus the strap value, giving 0x5A, 0x5B, 0x5C or 0x5D for strap codes 0 to 3. After the first byte following START (address in bits 7..1, R/W in bit 0), a matching address is acknowledged by pulling SDA low for the ninth clock.
- R3: On an address mismatch, SDA stays released for the whole transfer, including every acknowledge slot. Bytes sent before the next START or STOP change neither the registers nor the pointer.
- R4: In a write transfer (R/W = 0), the first byte after the address is acknowledged and its low 7 bits are loaded into the pointer. If STOP follows, the pointer keeps that value and no register changes.
- R5: Each further byte of a write transfer is acknowledged and stored in the register at the pointer, and the pointer then increments.
- R6: In a read transfer (R/W = 1), the block sends the register at the pointer, MSB first, and the pointer increments once for each byte sent.
- R7: A master ACK (SDA low in the ninth clock) after a read byte makes the block send the next byte. A NACK (SDA high) ends the read: SDA stays released until the next START or STOP.
- R8: The pointer is 7 bits wide and wraps from 0x7F to 0x00 on both writes and reads.
- R9: The block changes `sda_oe` only while SCL is low, and it never drives SCL.
- R10: A START in the middle of a byte abandons that byte without storing it, and the next byte is taken as an address.
- R11: After reset, SDA is released, the pointer is 0x00 and all 128 registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_sel | input | 2 | Address select strap, added to the base address |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The assertions assume the master keeps each SCL high and low phase several system clocks long. They also assume the master changes SDA only while SCL is low, except when it signals START or STOP, and that the strap stays constant during a transfer. Under these conditions, a change of `sda_oe` can only follow a synchronized SCL fall, and a START or STOP can never be seen while the block is holding SDA low. The bench master uses a 5-cycle quarter period for every bus phase, so each SCL phase lasts 10 system clocks. It changes the strap only while the bus is idle, so the stimulus stays inside these assumptions.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], raw_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= '1;
    else        prev_o <= sync_o;
  end

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_p,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_held_high;

  assign scl_held_high = scl_s & scl_p;
  assign scl_rise      = scl_s & ~scl_p;
  assign scl_fall      = ~scl_s & scl_p;
  assign start_evt     = scl_held_high & sda_p & ~sda_s;
  assign stop_evt      = scl_held_high & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h5A,
  parameter int         AW        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [1:0]        strap_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [AW-1:0]     ptr,
  output logic              sda_oe
);

  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);
  localparam logic [3:0] LAST_BIT  = 4'(BYTE_W - 1);

  tgt_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rnw;
  logic              m_ack;
  logic [6:0]        own_addr;
  logic              rx_state;
  logic              rx_done;

  assign own_addr = ADDR_BASE + {5'b0, strap_sel};
  assign rx_state = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDAT);
  assign rx_done  = rx_state && scl_fall && (bit_cnt == BITS_FULL);
  assign wr_en    = rx_done && (state == ST_WDAT) && !start_evt && !stop_evt;
  assign wr_data  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rnw     <= 1'b0;
      m_ack   <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_WDAT: begin
          if (scl_rise && bit_cnt < BITS_FULL) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (rx_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (rx_sh[7:1] == own_addr) begin
                rnw    <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IGNORE;
              end
            end else if (state == ST_CMD) begin
              ptr    <= rx_sh[AW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_CMD_ACK;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rnw) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr    <= ptr + 1'b1;
              state  <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sh[BYTE_W-2];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (m_ack) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr    <= ptr + 1'b1;
              state  <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IGNORE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h5A,
  parameter int         AW          = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_sel,
  output logic       sda_oe
);

  logic              scl_s, sda_s, scl_p, sda_p;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [AW-1:0]     ptr;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .sync_o ({scl_s, sda_s}),
    .prev_o ({scl_p, sda_p})
  );

  i2c_bus_cond u_cond (
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_p     (scl_p),
    .sda_p     (sda_p),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_tgt_fsm #(.ADDR_BASE(ADDR_BASE), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (sda_s),
    .strap_sel (strap_sel),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .sda_oe    (sda_oe)
  );

  i2c_regfile #(.AW(AW), .DW(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          wr_en,
  input logic [AW-1:0] ptr
);

  // R9: the open-drain enable moves only while the synchronized clock is low
  p_sda_quiet_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R1: a STOP leaves the data line released
  p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R10: a START (also mid-byte) leaves the data line released
  p_start_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R5 and R8: every stored byte advances the pointer by one, modulo the depth
  p_write_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R5: a byte is stored only after all its bits arrived, while the line is free
  p_write_line_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sda_oe);

endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .wr_en     (wr_en),
  .ptr       (ptr)
);

// File: tb/tb_i2c_regptr_target.sv
module tb_i2c_regptr_target;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic [1:0] strap = 2'd0;
  logic       sda_oe;
  wire        sda_bus = ~(m_sda_low | sda_oe);

  always #5 clk = ~clk;

  i2c_regptr_target dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .strap_sel (strap),
    .sda_oe    (sda_oe)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] mem_m [128];
  int         ptr_m = 0;
  bit         quiet_exp = 1'b0;
  bit         running = 1'b0;
  int         hi_cnt = 0;
  logic       oe_prev = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // per-clock model comparison
  always @(negedge clk) begin
    if (running) begin
      if (quiet_exp) chk("R3 line released during foreign transfer", sda_oe, 0);
      if (m_scl && hi_cnt >= 4) chk("R9 enable steady while SCL high", sda_oe, oe_prev);
    end
    oe_prev = sda_oe;
    hi_cnt  = m_scl ? hi_cnt + 1 : 0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1;     wq();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b0;     wq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b1;     wq();
    m_sda_low = 1'b0; wq();
  endtask

  task automatic wbit(input logic b);
    m_sda_low = ~b; wq();
    m_scl = 1'b1;   wq(); wq();
    m_scl = 1'b0;   wq();
  endtask

  task automatic rbit(output logic b);
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1;     wq();
    b = sda_bus;      wq();
    m_scl = 1'b0;     wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~give_ack);
  endtask

  function automatic logic is_own(input logic [6:0] a);
    return a == (7'h5A + {5'b0, strap});
  endfunction

  // write transfer: address, pointer byte, then n data bytes
  task automatic write_txn(input logic [6:0] a, input logic [7:0] cmd,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n);
    logic ak;
    logic [7:0] d [3];
    logic own;
    d[0] = d0; d[1] = d1; d[2] = d2;
    own = is_own(a);
    quiet_exp = ~own;
    bus_start();
    send_byte({a, 1'b0}, ak);
    chk(own ? "R2 own address acknowledged" : "R3 foreign address not acknowledged", ak, own);
    send_byte(cmd, ak);
    chk(own ? "R4 pointer byte acknowledged" : "R3 pointer byte ignored", ak, own);
    if (own) ptr_m = cmd & 8'h7F;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ak);
      chk(own ? "R5 data byte acknowledged" : "R3 data byte ignored", ak, own);
      if (own) begin
        mem_m[ptr_m] = d[i];
        ptr_m = (ptr_m + 1) % 128;
      end
    end
    bus_stop();
    quiet_exp = 1'b0;
  endtask

  // read transfer, optionally preceded by pointer write and repeated START
  task automatic read_txn(input logic [6:0] a, input bit set_ptr,
                          input logic [7:0] cmd, input int n, input string req);
    logic ak, rel;
    logic [7:0] v;
    bus_start();
    if (set_ptr) begin
      send_byte({a, 1'b0}, ak);
      chk("R2 address acknowledged before pointer byte", ak, 1);
      send_byte(cmd, ak);
      chk("R4 pointer byte acknowledged", ak, 1);
      ptr_m = cmd & 8'h7F;
      bus_start();
    end
    send_byte({a, 1'b1}, ak);
    chk("R6 read address acknowledged", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      chk(req, v, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 128;
    end
    rbit(rel);
    chk("R7 line released after master NACK", rel, 1);
    bus_stop();
  endtask

  initial begin
    logic ak;
    logic [7:0] v;
    for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    chk("R11 line released after reset", sda_oe, 0);
    chk("R11 bus idle high after reset", sda_bus, 1);

    // R11: pointer starts at 0 with cleared registers
    read_txn(7'h5A, 1'b0, 8'h00, 2, "R11 reset register value");

    // R5: burst write
    write_txn(7'h5A, 8'h10, 8'hA1, 8'hB2, 8'hC3, 3);
    // R4: pointer-only write, then separate read transfer
    write_txn(7'h5A, 8'h11, 8'h00, 8'h00, 8'h00, 0);
    read_txn(7'h5A, 1'b0, 8'h00, 2, "R4 read starts at stored pointer");
    // R6 and R7: repeated-START read of a multi-byte run
    read_txn(7'h5A, 1'b1, 8'h10, 3, "R6 read data with master ACK");
    // R6: pointer continued from previous read
    read_txn(7'h5A, 1'b0, 8'h00, 1, "R6 read continues after previous read");

    // R8: wrap on write and read
    write_txn(7'h5A, 8'h7E, 8'h11, 8'h22, 8'h33, 3);
    read_txn(7'h5A, 1'b1, 8'h7F, 2, "R8 read wraps past top register");
    read_txn(7'h5A, 1'b0, 8'h00, 1, "R8 pointer after wrapping read");
    read_txn(7'h5A, 1'b1, 8'h00, 1, "R8 write wrapped into register 0");

    // R3: foreign address write must not touch registers or pointer
    write_txn(7'h5A, 8'h12, 8'h00, 8'h00, 8'h00, 0);
    write_txn(7'h5B, 8'h10, 8'hFF, 8'hEE, 8'h00, 2);
    read_txn(7'h5A, 1'b0, 8'h00, 1, "R3 pointer kept across foreign transfer");
    read_txn(7'h5A, 1'b1, 8'h10, 2, "R3 registers kept across foreign transfer");

    // R2: strap selects the address
    strap = 2'd3;
    repeat (4) @(negedge clk);
    write_txn(7'h5D, 8'h30, 8'h77, 8'h00, 8'h00, 1);
    write_txn(7'h5A, 8'h30, 8'h99, 8'h00, 8'h00, 1);
    read_txn(7'h5D, 1'b1, 8'h30, 1, "R2 strap 3 address reaches registers");
    strap = 2'd2;
    repeat (4) @(negedge clk);
    write_txn(7'h5C, 8'h31, 8'h66, 8'h00, 8'h00, 1);
    read_txn(7'h5C, 1'b1, 8'h30, 2, "R2 strap 2 address reaches registers");
    strap = 2'd0;
    repeat (4) @(negedge clk);

    // R10: START in the middle of a data byte
    write_txn(7'h5A, 8'h20, 8'h5E, 8'h00, 8'h00, 1);
    bus_start();
    send_byte({7'h5A, 1'b0}, ak);
    chk("R10 address acknowledged", ak, 1);
    send_byte(8'h20, ak);
    chk("R10 pointer byte acknowledged", ak, 1);
    ptr_m = 8'h20;
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_start();
    send_byte({7'h5A, 1'b1}, ak);
    chk("R10 byte after aborting START is an address", ak, 1);
    recv_byte(1'b0, v);
    chk("R10 partial byte was not stored", v, mem_m[8'h20]);
    ptr_m = ptr_m + 1;
    bus_stop();

    // R1: after STOP, clock pulses get no response
    repeat (3) rbit(ak);
    chk("R1 no response after STOP", ak, 1);
    chk("R1 line released when idle", sda_oe, 0);

    running = 1'b0;
    repeat (4) @(negedge clk);
    report();
  end

endmodule